// File: doc/BRIEF.md
# SPI Controller Register and FIFO Front End

This block sits between a simple 32-bit register bus and the word-level serial engine of an SPI controller. Software configures the engine through a handful of storage registers (clock setting, transmit and receive word setting, frame setting) that are driven straight out to the engine. Outgoing words are written into an 8-entry transmit queue. Incoming words are collected in an 8-entry receive queue. Both queues sit behind one shared data address. A write to that address queues a word for the engine, and a read from it takes the oldest received word.

The engine takes transmit words through a valid/ready handshake. It delivers receive words with a one-cycle valid strobe and has no back-pressure. A word that arrives while the receive queue is full is lost and raises an overrun flag. Three event flags (transmit level reached, receive level reached, overrun) are held until software clears them by writing ones. The interrupt line is the OR of the flags that are enabled. Pin-level serial timing belongs to the engine and is not handled here.

Top module: `spi_regfe`

## Requirements
- R1: Registers are decoded on word index `bus_addr_i[5:2]` only when `bus_addr_i[1:0]` is 0. Control is at 0x00. Clock setting (0x04), transmit word setting (0x08), receive word setting (0x0C) and frame setting (0x10) each store the low CFG_W bits of the written value, read them back zero-extended, and drive them on their `cfg_*` outputs. Control keeps only bit 0. A misaligned access changes nothing.
- R2: While control bit 0 is clear, `tx_word_valid_o` stays low and receive words are ignored: they are not stored and raise no flag.
- R3: A write to 0x24 appends the low DATA_W bits to the transmit queue. A write while the queue is full is dropped. Words are offered to the engine oldest first, and the offered word holds until it is accepted.
- R4: A read of 0x24 returns the oldest received word and removes it. A read while the queue is empty returns 0. Read data appears on `bus_rdata_o` on the cycle after the access and holds until the next read.
- R5: Each queue holds FIFO_DEPTH (8) words. Status at 0x14 reads bit 7 = busy (engine busy or transmit queue not empty), bit 5 = transmit queue not full, bit 0 = receive queue not empty, and all other bits 0.
- R6: At 0x20, bit 12 flushes the transmit queue and bit 4 flushes the receive queue. Both flush bits read as 0. The queues empty at the clock edge after the write edge, so the next cycle's read still sees the old levels. Bits 11:8 (transmit level) and 3:0 (receive level) are stored and read back.
- R7: A receive word that arrives while enabled and with the receive queue full is discarded, and the overrun flag is set.
- R8: The transmit-level flag is set when an engine handshake leaves the transmit queue holding no more words than the transmit level field.
- R9: The receive-level flag is set when a word stored into the receive queue brings its level to at least the receive level field.
- R10: Reading 0x1C returns the flags: bit 4 transmit level, bit 3 receive level, bit 0 overrun. Writing 1 to a bit clears that flag, writing 0 leaves it. A flag set in the same cycle stays set.
- R11: Interrupt enables at 0x18 use the same bit positions (4, 3, 0). Other bits read 0. `irq_o` is high exactly when an enabled flag is pending.
- R12: After reset everything is cleared. Status reads 0x20, and `irq_o`, `tx_word_valid_o` and `ctrl_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| tx_word_valid_o | output | 1 | Transmit word offered to engine |
| tx_word_data_o | output | DATA_W | Offered transmit word |
| tx_word_ready_i | input | 1 | Engine accepts the offered word |
| rx_word_valid_i | input | 1 | Engine delivers a received word |
| rx_word_data_i | input | DATA_W | Received word |
| eng_busy_i | input | 1 | Engine is shifting |
| ctrl_en_o | output | 1 | Controller enable |
| cfg_clk_o | output | CFG_W | Clock setting |
| cfg_txw_o | output | CFG_W | Transmit word setting |
| cfg_rxw_o | output | CFG_W | Receive word setting |
| cfg_frame_o | output | CFG_W | Frame setting |
| irq_o | output | 1 | Interrupt request |

## Verification
Every state change here happens on the edge that ends the bus or engine cycle. Writes, engine handshakes and received words are visible on the ports at the following falling edge, where the bench samples. Register reads need one more edge: the value returned reflects the state before the read edge. For that reason the flush test reads status twice right after the flush write. The first read must still show the old levels and the second must show empty queues. Interrupt and flag effects of a clear or enable write are checked on the falling edge immediately after that write.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 6;
  localparam int THR_W  = 4;

  // word indices (byte offset / 4)
  localparam logic [3:0] IDX_CTRL = 4'h0;
  localparam logic [3:0] IDX_CLK  = 4'h1;
  localparam logic [3:0] IDX_TXW  = 4'h2;
  localparam logic [3:0] IDX_RXW  = 4'h3;
  localparam logic [3:0] IDX_FRM  = 4'h4;
  localparam logic [3:0] IDX_STAT = 4'h5;
  localparam logic [3:0] IDX_IEN  = 4'h6;
  localparam logic [3:0] IDX_ICLR = 4'h7;
  localparam logic [3:0] IDX_FCTL = 4'h8;
  localparam logic [3:0] IDX_DATA = 4'h9;

  // status bit positions
  localparam int ST_BUSY = 7;
  localparam int ST_TNF  = 5;
  localparam int ST_RNE  = 0;

  // queue-control bit positions
  localparam int FC_TXFL = 12;
  localparam int FC_RXFL = 4;
  localparam int FC_TXTH = 8;
  localparam int FC_RXTH = 0;

  // flag bit positions in the bus view
  localparam int IB_TC  = 4;
  localparam int IB_RC  = 3;
  localparam int IB_OVR = 0;

  // internal flag vector layout
  localparam int IRQ_N   = 3;
  localparam int IRQ_OVR = 0;
  localparam int IRQ_RC  = 1;
  localparam int IRQ_TC  = 2;
endpackage

// File: rtl/spi_fe_fifo.sv
module spi_fe_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush_i,
  input  logic                       push_i,
  input  logic [WIDTH-1:0]           data_i,
  input  logic                       pop_i,
  output logic [WIDTH-1:0]           head_o,
  output logic [$clog2(DEPTH):0]     count_o,
  output logic                       full_o,
  output logic                       empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush_i) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + PTR_W'(1);
      if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + PTR_W'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + CNT_W'(1);
        2'b01:   cnt_d = cnt_q - CNT_W'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // storage: written only on an accepted push, no reset needed
  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/spi_fe_regs.sv
module spi_fe_regs
  import spi_fe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic              tx_full_i,
  input  logic              tx_empty_i,
  input  logic              rx_empty_i,
  input  logic [DATA_W-1:0] rx_head_i,
  input  logic              eng_busy_i,
  input  logic [IRQ_N-1:0]  flags_i,
  output logic              ctrl_en_o,
  output logic [CFG_W-1:0]  cfg_clk_o,
  output logic [CFG_W-1:0]  cfg_txw_o,
  output logic [CFG_W-1:0]  cfg_rxw_o,
  output logic [CFG_W-1:0]  cfg_frame_o,
  output logic [IRQ_N-1:0]  ien_o,
  output logic [IRQ_N-1:0]  clr_o,
  output logic              tx_push_o,
  output logic [DATA_W-1:0] tx_wdata_o,
  output logic              rx_pop_o,
  output logic              tx_flush_o,
  output logic              rx_flush_o,
  output logic [THR_W-1:0]  tx_thr_o,
  output logic [THR_W-1:0]  rx_thr_o
);
  logic             aligned, wr_hit, rd_hit;
  logic [3:0]       idx;
  logic             we_ctrl, we_clk, we_txw, we_rxw, we_frm, we_ien, we_fctl;
  logic             en_q;
  logic [CFG_W-1:0] clk_q, txw_q, rxw_q, frm_q;
  logic [IRQ_N-1:0] ien_q, ien_d;
  logic [THR_W-1:0] txth_q, rxth_q;
  logic             txfl_q, rxfl_q, txfl_d, rxfl_d;
  logic [BUS_W-1:0] rd_word, rdata_q, stat_word, flag_word, ien_word;

  // ---------------- decode ----------------
  always_comb begin
    aligned = (bus_addr_i[1:0] == 2'b00);
    idx     = bus_addr_i[ADDR_W-1:2];
    wr_hit  = bus_sel_i && bus_wr_i && aligned;
    rd_hit  = bus_sel_i && !bus_wr_i && aligned;
    we_ctrl = wr_hit && (idx == IDX_CTRL);
    we_clk  = wr_hit && (idx == IDX_CLK);
    we_txw  = wr_hit && (idx == IDX_TXW);
    we_rxw  = wr_hit && (idx == IDX_RXW);
    we_frm  = wr_hit && (idx == IDX_FRM);
    we_ien  = wr_hit && (idx == IDX_IEN);
    we_fctl = wr_hit && (idx == IDX_FCTL);
  end

  // ---------------- next state ----------------
  always_comb begin
    ien_d = ien_q;
    ien_d[IRQ_TC]  = bus_wdata_i[IB_TC];
    ien_d[IRQ_RC]  = bus_wdata_i[IB_RC];
    ien_d[IRQ_OVR] = bus_wdata_i[IB_OVR];
    // flush requests live for one cycle only
    txfl_d = we_fctl && bus_wdata_i[FC_TXFL];
    rxfl_d = we_fctl && bus_wdata_i[FC_RXFL];
  end

  always_comb begin
    clr_o = '0;
    if (wr_hit && (idx == IDX_ICLR)) begin
      clr_o[IRQ_TC]  = bus_wdata_i[IB_TC];
      clr_o[IRQ_RC]  = bus_wdata_i[IB_RC];
      clr_o[IRQ_OVR] = bus_wdata_i[IB_OVR];
    end
  end

  // ---------------- read mux ----------------
  always_comb begin
    stat_word          = '0;
    stat_word[ST_BUSY] = eng_busy_i || !tx_empty_i;
    stat_word[ST_TNF]  = !tx_full_i;
    stat_word[ST_RNE]  = !rx_empty_i;
    flag_word          = '0;
    flag_word[IB_TC]   = flags_i[IRQ_TC];
    flag_word[IB_RC]   = flags_i[IRQ_RC];
    flag_word[IB_OVR]  = flags_i[IRQ_OVR];
    ien_word           = '0;
    ien_word[IB_TC]    = ien_q[IRQ_TC];
    ien_word[IB_RC]    = ien_q[IRQ_RC];
    ien_word[IB_OVR]   = ien_q[IRQ_OVR];
    rd_word            = '0;
    case (idx)
      IDX_CTRL: rd_word = BUS_W'(en_q);
      IDX_CLK:  rd_word = BUS_W'(clk_q);
      IDX_TXW:  rd_word = BUS_W'(txw_q);
      IDX_RXW:  rd_word = BUS_W'(rxw_q);
      IDX_FRM:  rd_word = BUS_W'(frm_q);
      IDX_STAT: rd_word = stat_word;
      IDX_IEN:  rd_word = ien_word;
      IDX_ICLR: rd_word = flag_word;
      IDX_FCTL: begin
        rd_word[FC_TXTH +: THR_W] = txth_q;
        rd_word[FC_RXTH +: THR_W] = rxth_q;
      end
      IDX_DATA: rd_word = rx_empty_i ? '0 : BUS_W'(rx_head_i);
      default:  rd_word = '0;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      clk_q   <= '0;
      txw_q   <= '0;
      rxw_q   <= '0;
      frm_q   <= '0;
      ien_q   <= '0;
      txth_q  <= '0;
      rxth_q  <= '0;
      txfl_q  <= 1'b0;
      rxfl_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (we_ctrl) en_q  <= bus_wdata_i[0];
      if (we_clk)  clk_q <= bus_wdata_i[CFG_W-1:0];
      if (we_txw)  txw_q <= bus_wdata_i[CFG_W-1:0];
      if (we_rxw)  rxw_q <= bus_wdata_i[CFG_W-1:0];
      if (we_frm)  frm_q <= bus_wdata_i[CFG_W-1:0];
      if (we_ien)  ien_q <= ien_d;
      if (we_fctl) begin
        txth_q <= bus_wdata_i[FC_TXTH +: THR_W];
        rxth_q <= bus_wdata_i[FC_RXTH +: THR_W];
      end
      txfl_q <= txfl_d;
      rxfl_q <= rxfl_d;
      if (rd_hit) rdata_q <= rd_word;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign ctrl_en_o   = en_q;
  assign cfg_clk_o   = clk_q;
  assign cfg_txw_o   = txw_q;
  assign cfg_rxw_o   = rxw_q;
  assign cfg_frame_o = frm_q;
  assign ien_o       = ien_q;
  assign tx_push_o   = wr_hit && (idx == IDX_DATA);
  assign tx_wdata_o  = bus_wdata_i[DATA_W-1:0];
  assign rx_pop_o    = rd_hit && (idx == IDX_DATA);
  assign tx_flush_o  = txfl_q;
  assign rx_flush_o  = rxfl_q;
  assign tx_thr_o    = txth_q;
  assign rx_thr_o    = rxth_q;
endmodule

// File: rtl/spi_fe_irq.sv
module spi_fe_irq
  import spi_fe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_N-1:0] set_i,
  input  logic [IRQ_N-1:0] clr_i,
  input  logic [IRQ_N-1:0] ien_i,
  output logic [IRQ_N-1:0] flags_o,
  output logic             irq_o
);
  logic [IRQ_N-1:0] flags_q, flags_d;

  // a new event wins over a simultaneous clear
  always_comb begin
    flags_d = (flags_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & ien_i);
endmodule

// File: rtl/spi_regfe.sv
module spi_regfe
  import spi_fe_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CFG_W      = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              tx_word_valid_o,
  output logic [DATA_W-1:0] tx_word_data_o,
  input  logic              tx_word_ready_i,
  input  logic              rx_word_valid_i,
  input  logic [DATA_W-1:0] rx_word_data_i,
  input  logic              eng_busy_i,
  output logic              ctrl_en_o,
  output logic [CFG_W-1:0]  cfg_clk_o,
  output logic [CFG_W-1:0]  cfg_txw_o,
  output logic [CFG_W-1:0]  cfg_rxw_o,
  output logic [CFG_W-1:0]  cfg_frame_o,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;
  localparam int CMP_W = ((CNT_W > THR_W) ? CNT_W : THR_W) + 1;

  logic              ctrl_en;
  logic              tx_push, rx_pop, tx_flush, rx_flush;
  logic [DATA_W-1:0] tx_wdata, rx_head, tx_head;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [THR_W-1:0]  tx_thr, rx_thr;
  logic [IRQ_N-1:0]  irq_flags, irq_set, irq_clr, irq_ien;
  logic              tx_pop, rx_take, rx_store, rx_drop;
  logic [CMP_W-1:0]  tx_lvl_after, rx_lvl_after;

  spi_fe_regs #(.DATA_W(DATA_W), .CFG_W(CFG_W)) regs_i (
    .clk, .rst_n,
    .bus_sel_i, .bus_wr_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .tx_full_i(tx_full), .tx_empty_i(tx_empty), .rx_empty_i(rx_empty),
    .rx_head_i(rx_head), .eng_busy_i, .flags_i(irq_flags),
    .ctrl_en_o(ctrl_en), .cfg_clk_o, .cfg_txw_o, .cfg_rxw_o, .cfg_frame_o,
    .ien_o(irq_ien), .clr_o(irq_clr),
    .tx_push_o(tx_push), .tx_wdata_o(tx_wdata), .rx_pop_o(rx_pop),
    .tx_flush_o(tx_flush), .rx_flush_o(rx_flush),
    .tx_thr_o(tx_thr), .rx_thr_o(rx_thr)
  );

  spi_fe_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
    .clk, .rst_n, .flush_i(tx_flush), .push_i(tx_push), .data_i(tx_wdata),
    .pop_i(tx_pop), .head_o(tx_head), .count_o(tx_cnt),
    .full_o(tx_full), .empty_o(tx_empty)
  );

  spi_fe_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
    .clk, .rst_n, .flush_i(rx_flush), .push_i(rx_store), .data_i(rx_word_data_i),
    .pop_i(rx_pop), .head_o(rx_head), .count_o(rx_cnt),
    .full_o(rx_full), .empty_o(rx_empty)
  );

  // engine-side handshakes, gated by the enable
  always_comb begin
    tx_word_valid_o = ctrl_en && !tx_empty;
    tx_pop          = tx_word_valid_o && tx_word_ready_i;
    rx_take         = ctrl_en && rx_word_valid_i;
    rx_store        = rx_take && !rx_full;
    rx_drop         = rx_take && rx_full;
    tx_lvl_after    = CMP_W'(tx_cnt) - CMP_W'(1);
    rx_lvl_after    = CMP_W'(rx_cnt) + CMP_W'(1);
    irq_set          = '0;
    irq_set[IRQ_OVR] = rx_drop;
    irq_set[IRQ_RC]  = rx_store && (rx_lvl_after >= CMP_W'(rx_thr));
    irq_set[IRQ_TC]  = tx_pop && (tx_lvl_after <= CMP_W'(tx_thr));
  end

  spi_fe_irq irq_i (
    .clk, .rst_n, .set_i(irq_set), .clr_i(irq_clr), .ien_i(irq_ien),
    .flags_o(irq_flags), .irq_o
  );

  assign tx_word_data_o = tx_head;
  assign ctrl_en_o      = ctrl_en;
endmodule

// File: rtl/spi_regfe_chk.sv
module spi_regfe_chk #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tx_word_valid_o,
  input logic                   tx_word_ready_i,
  input logic [DATA_W-1:0]      tx_word_data_o,
  input logic                   rx_word_valid_i,
  input logic                   ctrl_en,
  input logic [$clog2(DEPTH):0] tx_cnt,
  input logic [$clog2(DEPTH):0] rx_cnt,
  input logic                   rx_full,
  input logic                   tx_flush,
  input logic                   rx_flush,
  input logic [2:0]             irq_flags
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  AST_TX_VALID_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_word_valid_o |-> ctrl_en); // R2
  AST_TX_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_word_valid_o && !tx_word_ready_i && !tx_flush) |=> $stable(tx_word_data_o)); // R3
  AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CNT_W'(DEPTH)); // R5
  AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CNT_W'(DEPTH)); // R5
  AST_TX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (tx_cnt == '0)); // R6
  AST_RX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (rx_cnt == '0)); // R6
  AST_OVERRUN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && rx_word_valid_i && rx_full) |=> irq_flags[0]); // R7
  AST_OVERRUN_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && rx_word_valid_i && rx_full && !rx_flush) |=> (rx_cnt <= CNT_W'(DEPTH))); // R7
endmodule

bind spi_regfe spi_regfe_chk #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .tx_word_valid_o(tx_word_valid_o), .tx_word_ready_i(tx_word_ready_i),
  .tx_word_data_o(tx_word_data_o), .rx_word_valid_i(rx_word_valid_i),
  .ctrl_en(ctrl_en), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .rx_full(rx_full),
  .tx_flush(tx_flush), .rx_flush(rx_flush), .irq_flags(irq_flags)
);

// File: tb/spi_regfe_tb_top.sv
`timescale 1ns/1ps
module spi_regfe_tb_top;
  localparam int DATA_W = 32;
  localparam int CFG_W  = 16;

  logic              clk;
  logic              rst_n;
  logic              bus_sel, bus_wr;
  logic [5:0]        bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic              tx_valid, tx_ready, rx_valid, eng_busy, ctrl_en, irq;
  logic [DATA_W-1:0] tx_data, rx_data;
  logic [CFG_W-1:0]  cfg_clk, cfg_txw, cfg_rxw, cfg_frame;

  int n_chk;
  int n_fail;

  spi_regfe #(.DATA_W(DATA_W), .CFG_W(CFG_W), .FIFO_DEPTH(8)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .bus_sel_i(bus_sel), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .tx_word_valid_o(tx_valid), .tx_word_data_o(tx_data), .tx_word_ready_i(tx_ready),
    .rx_word_valid_i(rx_valid), .rx_word_data_i(rx_data), .eng_busy_i(eng_busy),
    .ctrl_en_o(ctrl_en), .cfg_clk_o(cfg_clk), .cfg_txw_o(cfg_txw),
    .cfg_rxw_o(cfg_rxw), .cfg_frame_o(cfg_frame), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  localparam logic [5:0] A_CTRL = 6'h00, A_CLK = 6'h04, A_TXW = 6'h08, A_RXW = 6'h0C,
                         A_FRM = 6'h10, A_STAT = 6'h14, A_IEN = 6'h18, A_ICLR = 6'h1C,
                         A_FCTL = 6'h20, A_DATA = 6'h24;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic read_chk(input logic [5:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    bus_read(a, v);
    chk(tag, v, exp);
  endtask

  task automatic rx_send(input logic [31:0] d);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic tx_take(input logic [31:0] exp, input string tag);
    chk({tag, " valid"}, 32'(tx_valid), 32'd1);
    chk({tag, " data"}, tx_data, exp);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 irq", 32'(irq), 0);
    chk("R12 tx_valid", 32'(tx_valid), 0);
    chk("R12 ctrl_en", 32'(ctrl_en), 0);
    read_chk(A_STAT, 32'h20, "R12 status");
    read_chk(A_FCTL, 32'h0, "R12 fifo ctrl");
    read_chk(A_ICLR, 32'h0, "R12 flags");
    read_chk(A_IEN, 32'h0, "R12 enables");
  endtask

  task automatic t_config();
    bus_write(A_CLK, 32'hA5A5_1234);
    bus_write(A_TXW, 32'h0000_0808);
    bus_write(A_RXW, 32'hFFFF_0708);
    bus_write(A_FRM, 32'h0001_C000);
    read_chk(A_CLK, 32'h1234, "R1 clk readback");
    read_chk(A_TXW, 32'h0808, "R1 txw readback");
    read_chk(A_RXW, 32'h0708, "R1 rxw readback");
    read_chk(A_FRM, 32'hC000, "R1 frame readback");
    chk("R1 cfg_clk", 32'(cfg_clk), 32'h1234);
    chk("R1 cfg_frame", 32'(cfg_frame), 32'hC000);
    chk("R1 cfg_rxw", 32'(cfg_rxw), 32'h0708);
    chk("R1 cfg_txw", 32'(cfg_txw), 32'h0808);
    bus_write(6'h05, 32'h0000_5555);
    read_chk(A_CLK, 32'h1234, "R1 misaligned write ignored");
    bus_write(A_CTRL, 32'hFFFF_FFFE);
    read_chk(A_CTRL, 32'h0, "R1 ctrl keeps bit0 only");
    chk("R1 ctrl_en low", 32'(ctrl_en), 0);
  endtask

  task automatic t_tx_gate();
    bus_write(A_DATA, 32'h11);
    bus_write(A_DATA, 32'h22);
    bus_write(A_DATA, 32'h33);
    chk("R2 no tx while disabled", 32'(tx_valid), 0);
    read_chk(A_STAT, 32'hA0, "R5 status busy with queued tx");
    bus_write(A_CTRL, 32'h1);
    chk("R2 tx offered once enabled", 32'(tx_valid), 1);
    tx_take(32'h11, "R3 order 0");
    tx_take(32'h22, "R3 order 1");
    tx_take(32'h33, "R3 order 2");
    chk("R3 tx drained", 32'(tx_valid), 0);
    read_chk(A_STAT, 32'h20, "R5 status idle");
  endtask

  task automatic t_tx_full();
    for (int i = 0; i < 9; i++) bus_write(A_DATA, 32'h100 + 32'(i));
    read_chk(A_STAT, 32'h80, "R5 tx full clears not-full bit");
    for (int i = 0; i < 8; i++) tx_take(32'h100 + 32'(i), "R3 full order");
    chk("R3 ninth word dropped", 32'(tx_valid), 0);
  endtask

  task automatic t_busy();
    eng_busy = 1'b1;
    read_chk(A_STAT, 32'hA0, "R5 busy from engine");
    eng_busy = 1'b0;
  endtask

  task automatic t_rx();
    logic [31:0] v;
    bus_write(A_ICLR, 32'h19);
    rx_send(32'hA1);
    rx_send(32'hA2);
    rx_send(32'hA3);
    read_chk(A_STAT, 32'h21, "R5 rx not empty");
    read_chk(A_DATA, 32'hA1, "R4 rx order 0");
    read_chk(A_DATA, 32'hA2, "R4 rx order 1");
    bus_read(A_DATA, v);
    chk("R4 rx order 2", v, 32'hA3);
    chk("R4 read data holds", bus_rdata, 32'hA3);
    read_chk(A_STAT, 32'h20, "R4 rx empty after reads");
    read_chk(A_DATA, 32'h0, "R4 empty read returns 0");
  endtask

  task automatic t_rx_disabled();
    bus_write(A_ICLR, 32'h19);
    bus_write(A_CTRL, 32'h0);
    rx_send(32'h55);
    bus_write(A_CTRL, 32'h1);
    read_chk(A_STAT, 32'h20, "R2 rx ignored while disabled");
    read_chk(A_ICLR, 32'h0, "R2 no flag while disabled");
  endtask

  task automatic t_overrun();
    bus_write(A_ICLR, 32'h19);
    for (int i = 0; i < 8; i++) rx_send(32'hC0 + 32'(i));
    read_chk(A_ICLR, 32'h08, "R7 no overrun at exactly full");
    rx_send(32'hEE);
    read_chk(A_ICLR, 32'h09, "R7 overrun flag");
    for (int i = 0; i < 8; i++) read_chk(A_DATA, 32'hC0 + 32'(i), "R7 kept words");
    read_chk(A_DATA, 32'h0, "R7 overrun word discarded");
    bus_write(A_ICLR, 32'h01);
    read_chk(A_ICLR, 32'h08, "R10 clear only overrun");
    bus_write(A_ICLR, 32'h08);
    read_chk(A_ICLR, 32'h00, "R10 clear receive flag");
  endtask

  task automatic t_rc_thr();
    bus_write(A_FCTL, 32'h3);
    rx_send(32'h1);
    rx_send(32'h2);
    read_chk(A_ICLR, 32'h0, "R9 below receive level");
    rx_send(32'h3);
    read_chk(A_ICLR, 32'h08, "R9 receive level reached");
    read_chk(A_FCTL, 32'h3, "R6 receive level readback");
    for (int i = 0; i < 3; i++) read_chk(A_DATA, 32'h1 + 32'(i), "R4 drain");
    bus_write(A_FCTL, 32'h0);
    bus_write(A_ICLR, 32'h19);
  endtask

  task automatic t_tc();
    bus_write(A_FCTL, 32'h200);
    for (int i = 0; i < 4; i++) bus_write(A_DATA, 32'h41 + 32'(i));
    tx_take(32'h41, "R8 take 0");
    read_chk(A_ICLR, 32'h0, "R8 above transmit level");
    tx_take(32'h42, "R8 take 1");
    read_chk(A_ICLR, 32'h10, "R8 transmit level reached");
    tx_take(32'h43, "R8 take 2");
    tx_take(32'h44, "R8 take 3");
    bus_write(A_FCTL, 32'h0);
    bus_write(A_ICLR, 32'h19);
    read_chk(A_ICLR, 32'h0, "R10 all cleared");
  endtask

  task automatic t_irq();
    logic [31:0] v;
    bus_write(A_IEN, 32'hFFFF_FFFF);
    read_chk(A_IEN, 32'h19, "R11 enable bits");
    chk("R11 no irq without flags", 32'(irq), 0);
    bus_write(A_IEN, 32'h10);
    rx_send(32'h77);
    chk("R11 masked flag no irq", 32'(irq), 0);
    bus_write(A_IEN, 32'h08);
    chk("R11 enabled flag raises irq", 32'(irq), 1);
    bus_write(A_ICLR, 32'h08);
    chk("R11 irq drops on clear", 32'(irq), 0);
    bus_read(A_DATA, v);
    bus_write(A_IEN, 32'h0);
  endtask

  task automatic t_flush();
    for (int i = 0; i < 3; i++) bus_write(A_DATA, 32'h90 + 32'(i));
    rx_send(32'hB0);
    rx_send(32'hB1);
    read_chk(A_STAT, 32'hA1, "R6 levels before flush");
    bus_write(A_FCTL, 32'h1315);
    chk("R6 tx still offered at write edge", 32'(tx_valid), 1);
    read_chk(A_STAT, 32'hA1, "R6 flush not yet applied");
    read_chk(A_STAT, 32'h20, "R6 both queues flushed");
    chk("R6 no tx after flush", 32'(tx_valid), 0);
    read_chk(A_FCTL, 32'h0305, "R6 flush bits self clear, levels kept");
    read_chk(A_DATA, 32'h0, "R6 rx empty after flush");
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0;
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    tx_ready = 0; rx_valid = 0; rx_data = '0; eng_busy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_tx_gate();
    t_tx_full();
    t_busy();
    t_rx();
    t_rx_disabled();
    t_overrun();
    t_rc_thr();
    t_tc();
    t_irq();
    t_flush();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule